// File: doc/BRIEF.md
# SPI Byte Controller with Master and Slave Modes

This block is a register-mapped SPI port that exchanges one byte per transfer, either as the bus master or as a selected slave. A small register interface provides a control word, a status word and a data location. In master mode, a write to the data location loads the shift register and starts an SCK generator derived from the system clock. Eight bits leave on MOSI while eight arrive on MISO, and the generator then stops. In slave mode the external SCK, SS and MOSI are brought into the system clock domain and edge-detected. MISO is driven only while the slave is selected.

Transmit goes straight through the shift register, so only one transmit byte is held at a time. Receive has a second stage: each completed byte is copied into a receive buffer, and data reads return that buffer. A completion flag, which can raise an interrupt, and a write-collision flag report progress. Both are cleared by a status read followed by a data access, or by an interrupt acknowledge. Chip select is left to the system: the block has no SS output.

Top module: `spi_byte_ctrl`

## Requirements
- R1: In master mode (control bit 1 = 1, control bit 2 = 1), a write to the data location (address 2) when idle produces exactly eight SCK pulses. SCK idles low. MOSI carries the byte MSB first and changes only after a falling SCK edge. MISO is sampled on each rising edge. SCK is low once the byte is done.
- R2: Control bits 4:3 select the SCK period in system clocks: 00 gives 4, 01 gives 16, 10 gives 64 and 11 gives 128. The completion flag is set exactly 8 periods after the clock edge that accepts the starting write.
- R3: When a byte completes, status bit 7 (address 1) becomes 1. The irq output is high exactly while that flag is set and control bit 0 is 1.
- R4: The completion flag and the collision flag are cleared by a data-location read or write that follows a status read which saw the completion flag set, or by a one-cycle pulse on irqAck.
- R5: A data write while a byte is in progress does not change the byte being shifted, and it sets status bit 6 (the collision flag). A slave is in progress once it has shifted at least one bit of the current byte while selected.
- R6: A data read returns the last completed received byte. If a second byte completes before the first is read, the first byte is overwritten.
- R7: In slave mode (control bit 1 = 0, control bit 2 = 1), misoOe is low while ssN is high, and SCK edges have no effect on the bit count. SCK, ssN and MOSI pass through two flip-flops, so misoOe rises on the second clock edge after ssN falls.
- R8: In slave mode, a byte written while deselected appears MSB first on misoOut once ssN is low. Each following bit appears after a falling SCK edge, and MOSI is sampled on rising SCK edges. SCK must stay below one quarter of the system clock.
- R9: After reset, status and data read as 0, and irq, sckOut and misoOe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (side effects only) |
| addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the current addr |
| irqAck | input | 1 | Interrupt acknowledge, clears both flags |
| irq | output | 1 | Interrupt request |
| sckOut | output | 1 | Master serial clock |
| mosiOut | output | 1 | Master serial data out |
| misoIn | input | 1 | Master serial data in |
| sckIn | input | 1 | Slave serial clock in |
| ssNIn | input | 1 | Slave select, active low |
| mosiIn | input | 1 | Slave serial data in |
| misoOut | output | 1 | Slave serial data out |
| misoOe | output | 1 | Output enable for misoOut (low = high impedance) |

## Verification
In master mode a behavioural reference tracks SCK, the flags and irq on every clock. Transfers use bit patterns with alternating, clustered and single set bits, so bit order and the MOSI/MISO exchange are checked in both directions. Transfers are timed at three divider settings to tell the period encodings apart. In slave mode, SCK pulses given while deselected, followed by a full selected byte, show whether deselected edges were counted. Back-to-back bytes without a read and data writes in mid-byte separate overrun behaviour from collision behaviour.

// File: rtl/spi_byte_pkg.sv
package spi_byte_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned CTRL_W = 5;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd2;

  localparam int unsigned BIT_IRQ_EN = 0;
  localparam int unsigned BIT_MASTER = 1;
  localparam int unsigned BIT_ON     = 2;
  localparam int unsigned BIT_DIV_LO = 3;

  typedef struct packed {
    logic loadTx;
    logic capture;
    logic shift;
    logic clearCnt;
  } shiftStrobes_t;
endpackage

// File: rtl/spi_byte_datapath.sv
module spi_byte_datapath
  import spi_byte_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  shiftStrobes_t     strb,
  input  logic [DATA_W-1:0] txByte,
  input  logic              serIn,
  output logic              serOut,
  output logic [DATA_W-1:0] rxByte,
  output logic              byteDone,
  output logic              midByte
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] rxBuf;
  logic [CNT_W-1:0]  bitCnt;
  logic              heldBit;
  logic [DATA_W-1:0] shiftNext;

  assign shiftNext = {shiftReg[DATA_W-2:0], heldBit};
  assign byteDone  = strb.shift && (bitCnt == LAST_BIT);
  assign midByte   = (bitCnt != '0);
  assign serOut    = shiftReg[DATA_W-1];
  assign rxByte    = rxBuf;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      rxBuf    <= '0;
      bitCnt   <= '0;
      heldBit  <= 1'b0;
    end else begin
      if (strb.capture) heldBit <= serIn;
      if (strb.loadTx) begin
        shiftReg <= txByte;
        bitCnt   <= '0;
      end else if (strb.shift) begin
        shiftReg <= shiftNext;
        bitCnt   <= byteDone ? '0 : bitCnt + CNT_W'(1);
      end
      if (strb.clearCnt) bitCnt <= '0;
      if (byteDone) rxBuf <= shiftNext;
    end
  end
endmodule

// File: rtl/spi_byte_control.sv
module spi_byte_control
  import spi_byte_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int HALF0  = 2,
  parameter int HALF1  = 8,
  parameter int HALF2  = 32,
  parameter int HALF3  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CTRL_W-1:0] ctrlWr,
  output logic [DATA_W-1:0] rdData,
  input  logic              irqAck,
  output logic              irq,
  output logic              sckOut,
  input  logic              sckIn,
  input  logic              ssNIn,
  input  logic              mosiIn,
  input  logic              misoIn,
  output logic              misoOe,
  output logic              masterMode,
  output shiftStrobes_t     strb,
  output logic              serIn,
  input  logic              byteDone,
  input  logic              midByte,
  input  logic [DATA_W-1:0] rxByte,
  output logic              masterActive,
  output logic              busy,
  output logic              doneFlag,
  output logic              wcolFlag
);
  localparam int DIV_CNT_W = $clog2(HALF3);

  logic [CTRL_W-1:0]    ctrlReg;
  logic                 irqEn, spiOn;
  logic [1:0]           divSel;
  logic [1:0]           sckSync, ssSync, mosiSync;
  logic                 sckPrev, sckRise, sckFall;
  logic                 slaveSel;
  logic                 dataWr, dataAcc, statRd;
  logic [DIV_CNT_W-1:0] divCnt, halfM1;
  logic                 tick, masterSck, flagArmed;

  assign irqEn      = ctrlReg[BIT_IRQ_EN];
  assign masterMode = ctrlReg[BIT_MASTER];
  assign spiOn      = ctrlReg[BIT_ON];
  assign divSel     = ctrlReg[BIT_DIV_LO +: 2];

  // two-stage synchronisers for the slave-side pins
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sckSync  <= 2'b00;
      ssSync   <= 2'b11;
      mosiSync <= 2'b00;
      sckPrev  <= 1'b0;
    end else begin
      sckSync  <= {sckSync[0], sckIn};
      ssSync   <= {ssSync[0], ssNIn};
      mosiSync <= {mosiSync[0], mosiIn};
      sckPrev  <= sckSync[1];
    end
  end

  assign sckRise  = sckSync[1] & ~sckPrev;
  assign sckFall  = ~sckSync[1] & sckPrev;
  assign slaveSel = spiOn & ~masterMode & ~ssSync[1];
  assign busy     = masterMode ? masterActive : (slaveSel & midByte);
  assign dataWr   = wrEn & (addr == ADDR_DATA);
  assign dataAcc  = (wrEn | rdEn) & (addr == ADDR_DATA);
  assign statRd   = rdEn & (addr == ADDR_STAT);
  assign serIn    = masterMode ? misoIn : mosiSync[1];

  always_comb begin
    unique case (divSel)
      2'd0:    halfM1 = DIV_CNT_W'(HALF0 - 1);
      2'd1:    halfM1 = DIV_CNT_W'(HALF1 - 1);
      2'd2:    halfM1 = DIV_CNT_W'(HALF2 - 1);
      default: halfM1 = DIV_CNT_W'(HALF3 - 1);
    endcase
  end

  assign tick = masterActive && (divCnt == halfM1);

  always_comb begin
    strb        = '0;
    strb.loadTx = dataWr & ~busy;
    if (masterMode && spiOn) begin
      strb.capture = tick & ~masterSck;
      strb.shift   = tick & masterSck;
    end else begin
      strb.capture  = slaveSel & sckRise;
      strb.shift    = slaveSel & sckFall;
      strb.clearCnt = ~slaveSel;
    end
  end

  // master clock generator
  always_ff @(posedge clk) begin
    if (!rstN) begin
      masterActive <= 1'b0;
      masterSck    <= 1'b0;
      divCnt       <= '0;
    end else if (masterMode && spiOn && dataWr && !masterActive) begin
      masterActive <= 1'b1;
      masterSck    <= 1'b0;
      divCnt       <= '0;
    end else if (masterActive) begin
      if (tick) begin
        divCnt    <= '0;
        masterSck <= ~masterSck;
        if (byteDone) masterActive <= 1'b0;
      end else begin
        divCnt <= divCnt + DIV_CNT_W'(1);
      end
    end
  end

  // control register and flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      doneFlag  <= 1'b0;
      wcolFlag  <= 1'b0;
      flagArmed <= 1'b0;
    end else begin
      if (wrEn && addr == ADDR_CTRL) ctrlReg <= ctrlWr;
      if (flagArmed && dataAcc) begin
        doneFlag  <= 1'b0;
        wcolFlag  <= 1'b0;
        flagArmed <= 1'b0;
      end
      if (irqAck) begin
        doneFlag  <= 1'b0;
        wcolFlag  <= 1'b0;
        flagArmed <= 1'b0;
      end
      if (statRd && doneFlag) flagArmed <= 1'b1;
      if (byteDone) doneFlag <= 1'b1;
      if (dataWr && busy) wcolFlag <= 1'b1;
    end
  end

  always_comb begin
    rdData = '0;
    unique case (addr)
      ADDR_CTRL: rdData[CTRL_W-1:0] = ctrlReg;
      ADDR_STAT: rdData[DATA_W-1 -: 2] = {doneFlag, wcolFlag};
      ADDR_DATA: rdData = rxByte;
      default:   rdData = '0;
    endcase
  end

  assign irq    = doneFlag & irqEn;
  assign sckOut = masterSck;
  assign misoOe = slaveSel;
endmodule

// File: rtl/spi_byte_ctrl.sv
module spi_byte_ctrl
  import spi_byte_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              irqAck,
  output logic              irq,
  output logic              sckOut,
  output logic              mosiOut,
  input  logic              misoIn,
  input  logic              sckIn,
  input  logic              ssNIn,
  input  logic              mosiIn,
  output logic              misoOut,
  output logic              misoOe
);
  shiftStrobes_t     strbW;
  logic              serInW, serOutW, byteDoneW, midByteW, masterModeW;
  logic              activeW, busyW, doneFlagW, wcolW;
  logic [DATA_W-1:0] rxByteW;

  spi_byte_control #(.DATA_W(DATA_W)) u_control (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .ctrlWr(wrData[CTRL_W-1:0]), .rdData(rdData), .irqAck(irqAck), .irq(irq),
    .sckOut(sckOut), .sckIn(sckIn), .ssNIn(ssNIn), .mosiIn(mosiIn),
    .misoIn(misoIn), .misoOe(misoOe), .masterMode(masterModeW), .strb(strbW),
    .serIn(serInW), .byteDone(byteDoneW), .midByte(midByteW), .rxByte(rxByteW),
    .masterActive(activeW), .busy(busyW), .doneFlag(doneFlagW), .wcolFlag(wcolW)
  );

  spi_byte_datapath #(.DATA_W(DATA_W)) u_datapath (
    .clk(clk), .rstN(rstN), .strb(strbW), .txByte(wrData), .serIn(serInW),
    .serOut(serOutW), .rxByte(rxByteW), .byteDone(byteDoneW), .midByte(midByteW)
  );

  assign mosiOut = masterModeW ? serOutW : 1'b0;
  assign misoOut = serOutW;
endmodule

// File: rtl/spi_byte_ctrl_checker.sv
module spi_byte_ctrl_checker (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [1:0] addr,
  input logic       irqAck,
  input logic       ssNIn,
  input logic       misoOe,
  input logic       sckOut,
  input logic       masterActive,
  input logic       busy,
  input logic       doneFlag,
  input logic       wcolFlag,
  input logic       byteDone
);
  // R1: master SCK rests low whenever no byte is running
  assert_sck_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    !masterActive |-> !sckOut);

  // R3: the completion flag only rises after the datapath finished a byte
  assert_flag_source_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> $past(byteDone));

  // R4: acknowledge clears the flag unless a new byte lands at the same edge
  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && !byteDone) |=> !doneFlag);

  // R5: a data write during a transfer leaves the collision flag set
  assert_collision_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 2'd2 && busy) |=> wcolFlag);

  // R7: MISO is enabled only when select was low two edges earlier
  assert_miso_hiz_R7: assert property (@(posedge clk) disable iff (!rstN)
    misoOe |-> !$past(ssNIn, 2));
endmodule

bind spi_byte_ctrl spi_byte_ctrl_checker u_checker (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .irqAck(irqAck),
  .ssNIn(ssNIn), .misoOe(misoOe), .sckOut(sckOut), .masterActive(activeW),
  .busy(busyW), .doneFlag(doneFlagW), .wcolFlag(wcolW), .byteDone(byteDoneW)
);

// File: tb/spi_byte_ctrl_test.sv
module spi_byte_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0, rdEn = 1'b0, irqAck = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic       irq, sckOut, mosiOut, misoIn, misoOut, misoOe;
  logic       sckIn = 1'b0, ssNIn = 1'b1, mosiIn = 1'b0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  spi_byte_ctrl uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irqAck(irqAck), .irq(irq),
    .sckOut(sckOut), .mosiOut(mosiOut), .misoIn(misoIn), .sckIn(sckIn),
    .ssNIn(ssNIn), .mosiIn(mosiIn), .misoOut(misoOut), .misoOe(misoOe)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // external slave device seen by the master
  logic [7:0] devTx = 8'd0;
  logic [7:0] devRx = 8'd0;
  int devFalls = 0;
  int devBase = 0;
  int sckRises = 0;
  always @(posedge sckOut) begin
    devRx <= {devRx[6:0], mosiOut};
    sckRises <= sckRises + 1;
  end
  always @(negedge sckOut) devFalls <= devFalls + 1;
  assign misoIn = devTx[7 - ((devFalls - devBase) & 7)];

  // behavioural reference for master mode
  bit       modelOn = 1'b0;
  bit [7:0] mCtrl;
  bit       mActive, mSck, mFlag, mWcol, mArmed;
  int       mCnt, mBits;

  function automatic int halfOf(input bit [1:0] sel);
    case (sel)
      2'd0: return 2;
      2'd1: return 8;
      2'd2: return 32;
      default: return 64;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCtrl = 0; mActive = 0; mSck = 0; mFlag = 0; mWcol = 0; mArmed = 0;
      mCnt = 0; mBits = 0;
    end else begin
      bit oldFlag, busyNow, setF;
      oldFlag = mFlag;
      busyNow = mActive;
      setF = 0;
      if (mActive) begin
        mCnt++;
        if (mCnt == halfOf(mCtrl[4:3])) begin
          mCnt = 0;
          mSck = !mSck;
          if (!mSck) begin
            mBits++;
            if (mBits == 8) begin mActive = 0; setF = 1; end
          end
        end
      end
      if (mArmed && (wrEn || rdEn) && addr == 2'd2) begin
        mFlag = 0; mWcol = 0; mArmed = 0;
      end
      if (irqAck) begin mFlag = 0; mWcol = 0; mArmed = 0; end
      if (rdEn && addr == 2'd1 && oldFlag) mArmed = 1;
      if (setF) mFlag = 1;
      if (wrEn && addr == 2'd2) begin
        if (busyNow) mWcol = 1;
        else if (mCtrl[1] && mCtrl[2]) begin
          mActive = 1; mCnt = 0; mBits = 0; mSck = 0;
        end
      end
      if (wrEn && addr == 2'd0) mCtrl = {3'b000, wrData[4:0]};
    end
  end

  // clock-by-clock comparison against the reference (R1, R2, R3)
  always @(negedge clk) begin
    if (modelOn && rstN && !done) begin
      checks++;
      if (sckOut !== mSck || irq !== (mFlag && mCtrl[0])) begin
        failures++;
        $display("FAIL R1/R2/R3 per-clock: sck=%0b irq=%0b expected sck=%0b irq=%0b",
                 sckOut, irq, mSck, mFlag && mCtrl[0]);
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic pulseAck();
    @(negedge clk);
    irqAck = 1'b1;
    @(negedge clk);
    irqAck = 1'b0;
  endtask

  task automatic waitMasterIdle();
    for (int i = 0; i < 3000 && (mActive || uut.sckOut); i++) @(negedge clk);
  endtask

  task automatic masterStart(input logic [7:0] tx, input logic [7:0] dev);
    devTx = dev;
    devBase = devFalls;
    busWrite(2'd2, tx);
  endtask

  task automatic slaveXfer(input logic [7:0] mo, input int collideAt, output logic [7:0] mi);
    ssNIn = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      mosiIn = mo[7-i];
      repeat (6) @(negedge clk);
      mi[7-i] = misoOut;
      sckIn = 1'b1;
      repeat (8) @(negedge clk);
      if (i == collideAt) busWrite(2'd2, 8'h11);
      sckIn = 1'b0;
      repeat (8) @(negedge clk);
    end
    ssNIn = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    logic [7:0] mi;
    int n;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R9 reset state
    busRead(2'd1, rv); check(rv == 8'h00, "R9 status after reset", rv, 0);
    busRead(2'd2, rv); check(rv == 8'h00, "R9 data after reset", rv, 0);
    check(!irq && !sckOut && !misoOe, "R9 outputs after reset", {irq, sckOut, misoOe}, 0);

    modelOn = 1'b1;
    // R1 basic master byte, divider 00, irq enabled
    busWrite(2'd0, 8'h07);
    n = sckRises;
    masterStart(8'hA5, 8'h3C);
    waitMasterIdle();
    check(sckRises - n == 8, "R1 eight SCK pulses", sckRises - n, 8);
    check(devRx == 8'hA5, "R1 MOSI byte MSB first", devRx, 8'hA5);
    check(irq == 1'b1, "R3 irq after byte", irq, 1);
    busRead(2'd1, rv); check(rv == 8'h80, "R3 status flag set", rv, 8'h80);
    busRead(2'd2, rv); check(rv == 8'h3C, "R6 received byte", rv, 8'h3C);
    busRead(2'd1, rv); check(rv == 8'h00, "R4 flag cleared by status then data", rv, 0);
    check(irq == 1'b0, "R4 irq dropped", irq, 0);

    // R2 divider 01: flag after 128 clocks
    busWrite(2'd0, 8'h0F);
    masterStart(8'h81, 8'h7E);
    n = 0;
    while (!irq && n < 3000) begin @(negedge clk); n++; end
    check(n == 128, "R2 period 16 timing", n, 128);
    check(devRx == 8'h81, "R1 MOSI pattern 81", devRx, 8'h81);
    pulseAck();
    check(irq == 1'b0, "R4 irqAck clears", irq, 0);
    busRead(2'd1, rv); check(rv == 8'h00, "R4 status after irqAck", rv, 0);

    // R2 divider 11: 1024 clocks
    busWrite(2'd0, 8'h1F);
    masterStart(8'h18, 8'hE7);
    n = 0;
    while (!irq && n < 3000) begin @(negedge clk); n++; end
    check(n == 1024, "R2 period 128 timing", n, 1024);
    pulseAck();

    // R3 flag without interrupt enable, R6 overrun
    busWrite(2'd0, 8'h06);
    masterStart(8'h12, 8'h55);
    waitMasterIdle();
    masterStart(8'h34, 8'hC6);
    waitMasterIdle();
    check(irq == 1'b0, "R3 irq masked", irq, 0);
    busRead(2'd1, rv); check(rv == 8'h80, "R3 flag with irq masked", rv, 8'h80);
    busRead(2'd2, rv); check(rv == 8'hC6, "R6 overrun keeps newest", rv, 8'hC6);

    // R5 collision in master mode
    pulseAck();
    masterStart(8'h5A, 8'hC3);
    repeat (10) @(negedge clk);
    busWrite(2'd2, 8'hFF);
    waitMasterIdle();
    check(devRx == 8'h5A, "R5 active byte unchanged", devRx, 8'h5A);
    busRead(2'd1, rv); check(rv == 8'hC0, "R5 collision flag", rv, 8'hC0);
    busRead(2'd2, rv); check(rv == 8'hC3, "R5 received byte intact", rv, 8'hC3);
    busRead(2'd1, rv); check(rv == 8'h00, "R4 both flags cleared", rv, 0);

    // slave mode
    modelOn = 1'b0;
    busWrite(2'd0, 8'h05);
    for (int i = 0; i < 5; i++) begin
      sckIn = 1'b1; repeat (8) @(negedge clk);
      sckIn = 1'b0; repeat (8) @(negedge clk);
    end
    check(misoOe == 1'b0, "R7 MISO hi-Z while deselected", misoOe, 0);
    busWrite(2'd2, 8'h96);
    busRead(2'd1, rv); check(rv == 8'h00, "R7 no flag or collision while deselected", rv, 0);
    @(negedge clk);
    ssNIn = 1'b0;
    @(negedge clk);
    check(misoOe == 1'b0, "R7 misoOe not after one edge", misoOe, 0);
    @(negedge clk);
    check(misoOe == 1'b1, "R7 misoOe after two edges", misoOe, 1);
    slaveXfer(8'h4B, -1, mi);
    check(mi == 8'h96, "R8 slave MISO byte", mi, 8'h96);
    check(misoOe == 1'b0, "R7 MISO released", misoOe, 0);
    check(irq == 1'b1, "R3 slave irq", irq, 1);
    busRead(2'd1, rv); check(rv == 8'h80, "R3 slave status", rv, 8'h80);
    busRead(2'd2, rv); check(rv == 8'h4B, "R6 slave received byte", rv, 8'h4B);

    // R5 collision in slave mode
    busWrite(2'd2, 8'h3E);
    slaveXfer(8'hD2, 2, mi);
    check(mi == 8'h3E, "R5 slave byte unchanged by mid-byte write", mi, 8'h3E);
    busRead(2'd1, rv); check(rv == 8'hC0, "R5 slave collision flag", rv, 8'hC0);
    busRead(2'd2, rv); check(rv == 8'hD2, "R6 slave second byte", rv, 8'hD2);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule